// File: doc/BRIEF.md
# Two-Stage Instruction Fetch and Next-Address Unit

This block is the front end of a 32-bit RISC core that has two pipeline stages. The first stage does nothing but fetch: it presents an instruction address to instruction memory and, on the next clock edge, latches the returned word into a single instruction register. That register is the only state handed to the second stage, which decodes, executes, accesses data memory and writes back.

The execute stage decides the control flow of the instruction now held in the instruction register. It reports its decision back through a two-bit redirect code, plus a register value that is used for register-indirect jumps. The unit builds branch and absolute-jump targets itself from the instruction register and the current fetch address. A redirect can only change the address of the fetch after the one already under way, so the instruction that follows any branch or jump always executes. This one-instruction delay slot needs no flush logic.

Top module: `fetch_front`

## Requirements
- R1: While `rst` is high, `imem_addr` is 0x0000_1000 and `ir_out` is all zeros (a no-op) from the first clock edge onward.
- R2: On the first cycle after `rst` falls, `imem_addr` is 0x0000_1000. With `ex_redir` = 2'b00 (no redirect), each later cycle's address is the previous one plus 4.
- R3: At every clock edge out of reset, `ir_out` takes the `imem_data` word that was presented for the current `imem_addr`.
- R4: `ex_redir` = 2'b01 (branch taken) makes the next address equal to the current `imem_addr`, which is the delay-slot address, plus `ir_out[15:0]` sign-extended and multiplied by 4. Both negative and positive offsets are supported.
- R5: `ex_redir` = 2'b10 (absolute jump) makes the next address equal to the top four bits of the current `imem_addr`, then `ir_out[25:0]`, then two zero bits. The top bits come from the delay-slot address even when that address has crossed a 256 MiB region boundary.
- R6: `ex_redir` = 2'b11 (register jump) makes the next address equal to `ex_reg_target`.
- R7: The word fetched in the cycle where a redirect is requested still enters `ir_out`. The redirect only changes the fetch after that one.
- R8: Every generated `imem_addr` has bits [1:0] equal to zero. A register target with nonzero low bits has them cleared.
- R9: Redirect requests that arrive while `rst` is high are ignored: the address stays at 0x0000_1000 and the instruction register stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_data | input | 32 | Word that instruction memory returns for `imem_addr` |
| ex_redir | input | 2 | Redirect code from execute: 00 none, 01 branch taken, 10 absolute jump, 11 register jump |
| ex_reg_target | input | 32 | Source register value for a register jump |
| imem_addr | output | 32 | Fetch address (the current PC) |
| ir_out | output | 32 | Instruction register passed to the execute stage |

## Verification
Any corrupted PC value shows up on `imem_addr` in the same cycle. Every later address then inherits the error, because each target is built from the current address. A wrong instruction register shows up on `ir_out` one edge after the faulty capture, and it then sends the next branch or jump to a wrong target one cycle later. The bench predicts both outputs for every cycle. It aims redirects at delay slots that sit on both sides of a 256 MiB boundary, and it uses negative, positive, zero-offset and misaligned targets, so that an error in the adder, in the sign extension or in the choice of base address differs at the ports within two cycles.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
   // Redirect code reported by the execute stage for the instruction in IR.
   typedef enum logic [1:0] {
      REDIR_NONE   = 2'b00,
      REDIR_BRANCH = 2'b01,
      REDIR_JUMP   = 2'b10,
      REDIR_REG    = 2'b11
   } redir_e;

   localparam int unsigned INSN_W = 32;
endpackage

// File: rtl/fetch_target_gen.sv
// Produces every candidate next fetch address from the current PC.
module fetch_target_gen #(
   parameter int unsigned XLEN          = 32,
   parameter int unsigned IMM_W         = 16,
   parameter int unsigned TGT_W         = 26,
   parameter bit          SHARED_ADDER  = 1'b1
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [TGT_W-1:0] ir_field,
   input  logic [XLEN-1:0]  reg_tgt,
   input  logic             take_branch,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  br_pc,
   output logic [XLEN-1:0]  jmp_pc,
   output logic [XLEN-1:0]  reg_pc
);
   localparam int unsigned EXT_W  = XLEN - IMM_W - 2;
   localparam int unsigned HIGH_W = XLEN - TGT_W - 2;

   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  br_ofs;
   logic [XLEN-1:0]  step4;

   assign imm    = ir_field[IMM_W-1:0];
   assign br_ofs = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign step4  = XLEN'(4);

   generate
      if (SHARED_ADDER) begin : g_shared
         // One carry chain: the increment is swapped for the offset.
         logic [XLEN-1:0] sum;
         assign sum    = pc + (take_branch ? br_ofs : step4);
         assign seq_pc = sum;
         assign br_pc  = sum;
      end else begin : g_split
         // Two carry chains side by side: the mux decision stays off the adder path.
         assign seq_pc = pc + step4;
         assign br_pc  = pc + br_ofs;
      end
   endgenerate

   assign jmp_pc = {pc[XLEN-1 -: HIGH_W], ir_field, 2'b00};
   assign reg_pc = reg_tgt & ~XLEN'(3);
endmodule

// File: rtl/fetch_nextpc_sel.sv
// Chooses the next address from the redirect code (the register's reset overrides all).
module fetch_nextpc_sel
   import fetch_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  redir_e          redir,
   input  logic [XLEN-1:0] seq_pc,
   input  logic [XLEN-1:0] br_pc,
   input  logic [XLEN-1:0] jmp_pc,
   input  logic [XLEN-1:0] reg_pc,
   output logic [XLEN-1:0] next_pc
);
   always_comb begin
      unique case (redir)
         REDIR_BRANCH: next_pc = br_pc;
         REDIR_JUMP:   next_pc = jmp_pc;
         REDIR_REG:    next_pc = reg_pc;
         default:      next_pc = seq_pc;
      endcase
   end
endmodule

// File: rtl/fetch_stage_reg.sv
// Pipeline register with synchronous load of a fixed value on reset.
module fetch_stage_reg #(
   parameter int unsigned     W       = 32,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
   end
endmodule

// File: rtl/fetch_front.sv
module fetch_front
   import fetch_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     IMM_W        = 16,
   parameter int unsigned     TGT_W        = 26,
   parameter logic [XLEN-1:0] RESET_VEC    = 32'h0000_1000,
   parameter bit              SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [INSN_W-1:0] imem_data,
   input  logic [1:0]        ex_redir,
   input  logic [XLEN-1:0]   ex_reg_target,
   output logic [XLEN-1:0]   imem_addr,
   output logic [INSN_W-1:0] ir_out
);
   // Elaboration-time parameter checks
   if (XLEN < TGT_W + 3) begin : g_bad_xlen
      $error("fetch_front: XLEN must leave room above the jump field");
   end
   if (IMM_W > TGT_W) begin : g_bad_imm
      $error("fetch_front: branch offset must fit inside the jump field");
   end
   if (TGT_W > INSN_W) begin : g_bad_tgt
      $error("fetch_front: jump field wider than an instruction");
   end
   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("fetch_front: reset vector must be word aligned");
   end

   redir_e          redir;
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] next_pc;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;
   logic [XLEN-1:0] reg_pc;

   assign redir = redir_e'(ex_redir);

   fetch_target_gen #(
      .XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W), .SHARED_ADDER(SHARED_ADDER)
   ) u_tgt (
      .pc          (pc_q),
      .ir_field    (ir_out[TGT_W-1:0]),
      .reg_tgt     (ex_reg_target),
      .take_branch (redir == REDIR_BRANCH),
      .seq_pc      (seq_pc),
      .br_pc       (br_pc),
      .jmp_pc      (jmp_pc),
      .reg_pc      (reg_pc)
   );

   fetch_nextpc_sel #(.XLEN(XLEN)) u_sel (
      .redir   (redir),
      .seq_pc  (seq_pc),
      .br_pc   (br_pc),
      .jmp_pc  (jmp_pc),
      .reg_pc  (reg_pc),
      .next_pc (next_pc)
   );

   fetch_stage_reg #(.W(XLEN), .RST_VAL(RESET_VEC)) u_pc (
      .clk (clk), .rst (rst), .d (next_pc), .q (pc_q)
   );

   // The instruction register: the only state crossing into execute.
   fetch_stage_reg #(.W(INSN_W), .RST_VAL('0)) u_ir (
      .clk (clk), .rst (rst), .d (imem_data), .q (ir_out)
   );

   assign imem_addr = pc_q;
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     IMM_W     = 16,
   parameter int unsigned     TGT_W     = 26,
   parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
   input logic            clk,
   input logic            rst,
   input logic [31:0]     imem_data,
   input logic [1:0]      ex_redir,
   input logic [XLEN-1:0] ex_reg_target,
   input logic [XLEN-1:0] imem_addr,
   input logic [31:0]     ir_out
);
   localparam int unsigned HIGH_W = XLEN - TGT_W - 2;

   logic            rst_d;
   logic [XLEN-1:0] br_ofs;

   always_ff @(posedge clk) rst_d <= rst;

   assign br_ofs = {{(XLEN-IMM_W-2){ir_out[IMM_W-1]}}, ir_out[IMM_W-1:0], 2'b00};

   // R1 and R9: after an edge taken in reset the outputs are at their reset values.
   always @(negedge clk) begin
      if (rst_d === 1'b1) begin
         a_r1_reset_state: assert (imem_addr == RESET_VEC && ir_out == '0)
            else $error("reset state wrong");
      end
   end

   a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
      (ex_redir == 2'b00) |=> imem_addr == $past(imem_addr) + XLEN'(4));

   a_r3_ir_capture: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ir_out == $past(imem_data));

   a_r4_branch_target: assert property (@(posedge clk) disable iff (rst)
      (ex_redir == 2'b01) |=> imem_addr == $past(imem_addr) + $past(br_ofs));

   a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
      (ex_redir == 2'b10) |=> imem_addr ==
         {$past(imem_addr[XLEN-1 -: HIGH_W]), $past(ir_out[TGT_W-1:0]), 2'b00});

   a_r6_reg_target: assert property (@(posedge clk) disable iff (rst)
      (ex_redir == 2'b11) |=> imem_addr == ($past(ex_reg_target) & ~XLEN'(3)));

   a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
      imem_addr[1:0] == 2'b00);
endmodule

bind fetch_front fetch_front_chk #(
   .XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W), .RESET_VEC(RESET_VEC)
) u_fetch_front_chk (
   .clk           (clk),
   .rst           (rst),
   .imem_data     (imem_data),
   .ex_redir      (ex_redir),
   .ex_reg_target (ex_reg_target),
   .imem_addr     (imem_addr),
   .ir_out        (ir_out)
);

// File: tb/test_fetch_front.sv
`timescale 1ns/1ps
module test_fetch_front;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] imem_data;
   logic [1:0]  ex_redir;
   logic [31:0] ex_reg_target;
   logic [31:0] imem_addr;
   logic [31:0] ir_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Scoreboard: each entry is {expected address, expected IR} with requirement tags.
   logic [63:0] exp_q[$];
   string       pc_tag_q[$];
   string       ir_tag_q[$];

   // Bench model of the architectural state
   logic [31:0] m_pc;
   logic [31:0] m_ir;

   always #2.5 clk = ~clk;

   fetch_front i_fetch_front (
      .clk (clk), .rst (rst), .imem_data (imem_data), .ex_redir (ex_redir),
      .ex_reg_target (ex_reg_target), .imem_addr (imem_addr), .ir_out (ir_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: presents one cycle of stimulus, predicts the next state, then waits.
   task automatic step(input logic [31:0] word, input logic [1:0] rd,
                       input logic [31:0] rtgt, input string pc_tag, input string ir_tag);
      logic [31:0] nxt;
      imem_data     = word;
      ex_redir      = rd;
      ex_reg_target = rtgt;
      case (rd)
         2'b01:   nxt = m_pc + ({{14{m_ir[15]}}, m_ir[15:0], 2'b00});
         2'b10:   nxt = {m_pc[31:28], m_ir[25:0], 2'b00};
         2'b11:   nxt = {rtgt[31:2], 2'b00};
         default: nxt = m_pc + 32'd4;
      endcase
      exp_q.push_back({nxt, word});
      pc_tag_q.push_back(pc_tag);
      ir_tag_q.push_back(ir_tag);
      m_pc = nxt;
      m_ir = word;
      @(negedge clk);
   endtask

   // Monitor: compares the design against the queue just after each edge.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [63:0] e;
         string       pt, it;
         e  = exp_q.pop_front();
         pt = pc_tag_q.pop_front();
         it = ir_tag_q.pop_front();
         check(pt, imem_addr, e[63:32]);
         check(it, ir_out, e[31:0]);
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst           = 1'b1;
      imem_data     = 32'hDEAD_BEEF;
      ex_redir      = 2'b11;          // R9: redirect requested during reset
      ex_reg_target = 32'h0000_5550;
      repeat (3) @(negedge clk);
      check("R1", imem_addr, 32'h0000_1000);
      check("R1", ir_out, 32'h0);
      ex_redir = 2'b01;
      @(negedge clk);
      check("R9", imem_addr, 32'h0000_1000);
      check("R9", ir_out, 32'h0);

      rst = 1'b0;
      #0.5;
      check("R2", imem_addr, 32'h0000_1000);
      m_pc = 32'h0000_1000;
      m_ir = 32'h0;

      // Branch with offset -4, then its delay slot with the branch taken.
      step({6'h04, 5'd1, 5'd2, 16'hFFFC}, 2'b00, 32'h0, "R2", "R3");
      step(32'h1234_5678, 2'b01, 32'h0, "R4", "R7");        // 0x1004 - 16 = 0xFF4
      // Absolute jump back to 0x1000
      step({6'h02, 26'h000_0400}, 2'b00, 32'h0, "R2", "R3");
      step(32'hAAAA_5555, 2'b10, 32'h0, "R5", "R7");
      // Register jump to a misaligned value
      step(32'h0000_0008, 2'b00, 32'h0, "R2", "R3");
      step(32'h5555_AAAA, 2'b11, 32'h0000_2003, "R8", "R7"); // -> 0x2000
      // Move to 0x0FFFFFFC so the jump's delay slot is at 0x10000000.
      step(32'h0F0F_0F0F, 2'b11, 32'h0FFF_FFFF, "R8", "R3");
      step({6'h02, 26'h000_0010}, 2'b00, 32'h0, "R2", "R3");
      step(32'h0BAD_F00D, 2'b10, 32'h0, "R5", "R7");         // -> 0x10000040
      // Large positive branch offset
      step({6'h05, 5'd3, 5'd4, 16'h7FFF}, 2'b00, 32'h0, "R2", "R3");
      step(32'h0000_0000, 2'b01, 32'h0, "R4", "R7");
      // Zero offset branch: target is the delay-slot address itself.
      step({6'h04, 5'd0, 5'd0, 16'h0000}, 2'b00, 32'h0, "R2", "R3");
      step(32'hFFFF_FFFF, 2'b01, 32'h0, "R4", "R7");
      // Register jump to an aligned value, then straight-line code.
      step(32'h2222_2222, 2'b11, 32'h8000_0000, "R6", "R3");
      for (int k = 0; k < 6; k++)
         step(32'h3000_0000 + 32'(k), 2'b00, 32'h0, "R2", "R3");
      // Re-enter reset with a redirect pending.
      rst      = 1'b1;
      ex_redir = 2'b10;
      @(negedge clk);
      @(negedge clk);
      check("R9", imem_addr, 32'h0000_1000);
      check("R1", ir_out, 32'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule